// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked front-end for a 64K x 16 asynchronous static RAM. A client presents one read or write at a time: a 16-bit word address, 16 bits of write data, a 2-bit lane mask and a direction bit. The controller accepts the request when it is idle. It then steps the memory's active-low chip select, output gate, write strobe and two lane strobes through a fixed sequence. When the access completes it raises a one-cycle completion pulse. For reads, the captured word is presented with that pulse.

Every timing window is a parameter given in nanoseconds. Each window is turned into a cycle count by rounding up against the clock period. The controller drives the shared data bus only inside the write phase, and only after a cycle in which the memory's output gate is already off. Between accesses chip select returns high, so the memory sits in standby and its bus floats.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and whenever no access is in progress, chip select, output gate, write strobe and both lane strobes are high, the bus drive enable is 0 and `req_ready` is 1.
- R2: A read holds chip select and output gate low with the write strobe high for RD_CYC cycles. RD_CYC is the largest of ceil(T_RC/P), ceil(T_AA/P) and ceil(T_OE/P), where P is the clock period; it is 7 at the default values. The word on the bus in the last of those cycles appears on `rsp_rdata` in the cycle that `rsp_valid` is high. The memory address equals the request address for the whole access.
- R3: Mask bit 0 selects bits 7:0 and drives the lower lane strobe low. Mask bit 1 selects bits 15:8 and drives the upper lane strobe low. A write changes only the selected lanes; mask 00 changes nothing. Read data bits in unselected lanes are returned as 0.
- R4: A write first spends one turnaround cycle with chip select low, output gate high, write strobe high and the bus not driven. It then holds the write strobe low with the data driven for WP_CYC cycles, where WP_CYC = max(ceil(T_WP/P), ceil(T_DW/P)), which is 4 at the default values. Finally it keeps the data driven with the strobe high for END_CYC = max(1, ceil(T_OW/P)) cycles.
- R5: The write strobe and the output gate are never low together.
- R6: The bus drive enable is 1 only while chip select is low and the output gate is high. It rises only after a cycle with the output gate high and chip select low.
- R7: Counted from the clock edge that accepts a request, `rsp_valid` rises 1+RD_CYC edges later for a read and 1+1+WP_CYC+END_CYC edges later for a write: 8 and 7 edges at the default values.
- R8: `rsp_valid` is a single-cycle pulse, one per accepted request. `req_ready` is 0 while an access is in progress, and requests presented then are ignored.
- R9: In the cycle that `rsp_valid` is high, chip select is already high, so at least one standby cycle separates consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| req_ready | output | 1 | Idle and able to accept |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, unselected lanes zero |
| mem_addr | output | AW | Address to memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the pad drivers |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The hardest condition to reach from the ports is a new request arriving while an access is still in progress. It must be ignored, yet the controller becomes able to accept it in the same cycle that the completion pulse appears. The bench reaches this by holding `req_valid` high with a conflicting write for the whole length of some accesses and dropping it just before the edge that would accept it. It then reads the conflicting address back to show that nothing landed there. A memory model that drives recognisable filler on unselected lanes exposes any lane leak.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW            = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 30,
  parameter int T_WP_NS       = 40,
  parameter int T_DW_NS       = 35,
  parameter int T_OW_NS       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);

  function automatic int cyc(input int t_ns);
    return (t_ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC   = mx(1, mx(cyc(T_RC_NS), mx(cyc(T_AA_NS), cyc(T_OE_NS))));
  localparam int WP_CYC   = mx(1, mx(cyc(T_WP_NS), cyc(T_DW_NS)));
  localparam int END_CYC  = mx(1, cyc(T_OW_NS));
  localparam int TURN_CYC = 1;
  localparam int CW       = $clog2(mx(RD_CYC, mx(WP_CYC, END_CYC)) + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WP, S_END} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [15:0]   d_q;
  logic [1:0]    be_q;
  logic [15:0]   rd_q;
  logic          done_q;
  logic          active;
  logic [15:0]   lane_mask;

  assign lane_mask = {{8{be_q[1]}}, {8{be_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      a_q    <= '0;
      d_q    <= '0;
      be_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q  <= req_addr;
          d_q  <= req_wdata;
          be_q <= req_be;
          cnt  <= '0;
          st   <= req_write ? S_TURN : S_RD;
        end
        S_RD: if (cnt == CW'(RD_CYC - 1)) begin
          rd_q   <= mem_dq_in & lane_mask;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_TURN: if (cnt == CW'(TURN_CYC - 1)) begin
          cnt <= '0;
          st  <= S_WP;
        end else cnt <= cnt + 1'b1;
        S_WP: if (cnt == CW'(WP_CYC - 1)) begin
          cnt <= '0;
          st  <= S_END;
        end else cnt <= cnt + 1'b1;
        S_END: if (cnt == CW'(END_CYC - 1)) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active     = (st != S_IDLE);
  assign req_ready  = !active;
  assign rsp_valid  = done_q;
  assign rsp_rdata  = rd_q;
  assign mem_addr   = a_q;
  assign mem_ce_n   = !active;
  assign mem_oe_n   = (st != S_RD);
  assign mem_we_n   = (st != S_WP);
  assign mem_lb_n   = !(active && be_q[0]);
  assign mem_ub_n   = !(active && be_q[1]);
  assign mem_dq_out = d_q;
  assign mem_dq_oe  = (st == S_WP) || (st == S_END);

  // checker state: length of the current write strobe
  logic [CW-1:0] we_lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_lo_cnt <= '0;
    else if (mem_we_n) we_lo_cnt <= '0;
    else               we_lo_cnt <= we_lo_cnt + 1'b1;
  end

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

  assert_we_blocks_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_drive_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  assert_drive_after_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && !$past(mem_ce_n) && $past(mem_we_n)));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= CW'(WP_CYC)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_done_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_ce_n);

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] mdl [256];
  logic [15:0] expv [256];

  always #5 clk = ~clk;

  sram_ctrl u0 (.clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_be,
    .req_ready, .rsp_valid, .rsp_rdata, .mem_addr, .mem_ce_n, .mem_oe_n, .mem_we_n,
    .mem_ub_n, .mem_lb_n, .mem_dq_out, .mem_dq_oe, .mem_dq_in);

  // memory model: filler on unselected lanes, floating pattern when not driving
  assign mem_dq_in = (!mem_ce_n && mem_we_n && !mem_oe_n) ?
    {mem_ub_n ? 8'hA5 : mdl[mem_addr[7:0]][15:8], mem_lb_n ? 8'h5A : mdl[mem_addr[7:0]][7:0]} :
    16'hDEAD;

  always @(posedge mem_we_n) begin
    if (rst_n && mem_ce_n === 1'b0) begin
      if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
  end

  function automatic logic [15:0] msk(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] be);
    return (old & ~msk(be)) | (d & msk(be));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit junk);
    int n = 1, oe_lo = 0, we_lo = 0;
    bit addr_ok = 1, drive_ok = 1, turn_ok = 1, ready_ok = 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    if (junk) begin
      req_write = 1; req_addr = a ^ 16'h0001; req_wdata = $urandom; req_be = 2'b11;
    end else req_valid = 0;
    for (int k = 0; k < 40; k++) begin
      if (rsp_valid) break;
      if (!mem_oe_n) oe_lo++;
      if (!mem_we_n) we_lo++;
      if (mem_addr != a) addr_ok = 0;
      if (mem_dq_oe && !mem_oe_n) drive_ok = 0;
      if (req_ready) ready_ok = 0;
      if (wr && n == 1 && !(mem_ce_n == 0 && mem_oe_n && mem_we_n && !mem_dq_oe)) turn_ok = 0;
      n++;
      @(negedge clk);
    end
    req_valid = 0;
    chk(rsp_valid, "R8 done seen", rsp_valid, 1);
    chk(n == (wr ? 7 : 8), "R7 latency", n, wr ? 7 : 8);
    chk(addr_ok, "R2 address held", addr_ok, 1);
    chk(drive_ok, "R6 no contention", drive_ok, 1);
    chk(ready_ok, "R8 ready low while busy", ready_ok, 1);
    chk(mem_ce_n, "R9 standby at done", mem_ce_n, 1);
    if (wr) begin
      chk(turn_ok, "R4 turnaround", turn_ok, 1);
      chk(we_lo == 4, "R4 strobe cycles", we_lo, 4);
      chk(oe_lo == 0, "R5 gate off in write", oe_lo, 0);
      expv[a[7:0]] = merge(expv[a[7:0]], d, be);
    end else begin
      chk(oe_lo == 7, "R2 gate cycles", oe_lo, 7);
      chk(rsp_rdata == (expv[a[7:0]] & msk(be)), "R3 read data", rsp_rdata, expv[a[7:0]] & msk(be));
    end
    @(negedge clk);
    chk(!rsp_valid && mem_ce_n && req_ready, "R1 idle after done", {rsp_valid, mem_ce_n, req_ready}, 3'b011);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mdl[i] = '0; expv[i] = '0; end
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe} == 6'b111110,
        "R1 reset pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 ready after reset", {req_ready, rsp_valid}, 2'b10);
    access(1, 16'h1210, 16'hBEEF, 2'b11, 0);
    access(0, 16'h1210, 16'h0000, 2'b11, 0);
    access(1, 16'h1210, 16'h0077, 2'b01, 0);  // R3 low lane only
    access(1, 16'h1210, 16'h6600, 2'b10, 0);  // R3 high lane only
    access(0, 16'h1210, 16'h0000, 2'b11, 0);
    access(1, 16'h1210, 16'hFFFF, 2'b00, 0);  // R3 empty mask
    access(0, 16'h1210, 16'h0000, 2'b11, 0);
    access(0, 16'h1210, 16'h0000, 2'b01, 0);  // R3 upper lane reads zero
    access(1, 16'h00FF, 16'h1234, 2'b11, 1);  // R8 busy request ignored
    access(0, 16'h00FE, 16'h0000, 2'b11, 0);
    access(0, 16'hFFFF, 16'h0000, 2'b10, 1);
    access(0, 16'hFFFE, 16'h0000, 2'b11, 0);
    for (int i = 0; i < 300; i++) begin
      a = $urandom;
      access($urandom_range(1, 0) == 1, a, 16'($urandom), 2'($urandom), $urandom_range(3, 0) == 0);
    end
    for (int i = 0; i < 256; i++)
      access(0, 16'(i), 16'h0000, 2'b11, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule